// File: doc/BRIEF.md
# Ping-Pong Endpoint Packet Buffer

This block holds two packet buffers for a single endpoint and hands them back and forth between a CPU byte port and a USB-side packet port. While one side works on one buffer, the other side can work on the other, so register traffic and bus traffic on the same endpoint overlap. A parameter selects the direction. For an IN endpoint the CPU is the producer and the USB side is the consumer. For an OUT endpoint the USB side produces and the CPU consumes.

The producer fills the buffer it currently owns and then commits it. For IN, the CPU commits by writing the byte count. For OUT, the USB side commits with an end-of-packet strobe. The commit passes that buffer to the consumer and moves the producer to the other buffer. The consumer releases a buffer when it is done with it: the USB side after the host acknowledges an IN packet, or the CPU after it has unloaded an OUT packet. When the USB side has nothing it can use, it answers with NAK. The interrupt flag follows ownership. For IN it means the CPU may load a packet. For OUT it means a packet is waiting.

Top module: `ep_pingpong_buf`

## Requirements
- R1: After reset, and after the cycle in which `bus_reset_i` is high, both buffers are empty and both sides point at buffer 0. In IN mode `irq_o`=1, `usb_nak_o`=1, `usb_len_o`=0 and `cpu_cnt_o`=0. In OUT mode `irq_o`=0 and `usb_nak_o`=0.
- R2: IN mode. Each `cpu_wr_i` stores `cpu_wdata_i` at the next byte position of the CPU-side buffer. A `cpu_cnt_wr_i` arms that buffer with the count and moves the CPU to the other buffer, starting at byte 0.
- R3: IN mode. `irq_o` is 1 while the CPU-side buffer is unarmed. It drops to 0 only when both buffers are armed.
- R4: IN mode. `usb_nak_o` is 1 exactly when the USB-side buffer is unarmed. Otherwise `usb_len_o` shows its count and `usb_rdata_o` shows its bytes in write order, with `usb_rd_i` advancing one byte.
- R5: The consumer side releases its buffer with one strobe (`usb_done_i` in IN mode, `cpu_ack_i` in OUT mode) and then moves to the other buffer. Buffers are consumed in strictly alternating order, the same order in which they were committed.
- R6: `usb_rewind_i` returns the USB byte position to 0 without changing ownership. In IN mode this lets a packet be resent from its first byte.
- R7: Counts are 7 bits wide. A count write above DEPTH (64) is stored as DEPTH. `cpu_cnt_o[7]` always reads 0. `cpu_cnt_o` shows the count of the CPU-side buffer while that buffer holds a committed packet, and 0 otherwise.
- R8: IN mode. When the CPU-side buffer is already armed, `cpu_wr_i` and `cpu_cnt_wr_i` have no effect on data, count or position.
- R9: OUT mode. Each `usb_wr_i` stores a byte into the free USB-side buffer. `usb_done_i` commits it with a count equal to the number of bytes stored, sets `irq_o`, and makes the bytes readable through `cpu_rdata_o` / `cpu_rd_i`.
- R10: OUT mode. `usb_nak_o` is 1 when both buffers hold packets. While it is 1, `usb_wr_i` and `usb_done_i` are ignored.
- R11: OUT mode. `cpu_ack_i` clears `irq_o` unless the other buffer also holds a packet, in which case `irq_o` stays 1 and that packet's count and data appear.
- R12: OUT mode. Bytes beyond DEPTH in one packet are dropped, so the count saturates at DEPTH. `usb_rewind_i` discards a partial packet.
- R13: `bus_reset_i` empties both buffers in the middle of traffic. Packets that were armed or received are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_reset_i | input | 1 | USB bus reset, empties both buffers |
| cpu_wr_i | input | 1 | CPU byte write strobe (stores data in IN mode) |
| cpu_wdata_i | input | 8 | CPU write byte |
| cpu_rd_i | input | 1 | CPU byte read strobe, advances the CPU position |
| cpu_rdata_o | output | 8 | Byte at the CPU position of the CPU-side buffer |
| cpu_cnt_wr_i | input | 1 | Byte-count write, arms the buffer (IN mode) |
| cpu_cnt_i | input | 7 | Byte count written by the CPU |
| cpu_cnt_o | output | 8 | Count of the CPU-side packet, bit 7 reads 0 |
| cpu_ack_i | input | 1 | CPU releases the current packet (OUT mode) |
| irq_o | output | 1 | Buffer-available (IN) or data-available (OUT) |
| usb_nak_o | output | 1 | USB side must answer NAK |
| usb_len_o | output | 7 | Count of the USB-side packet (IN mode) |
| usb_rd_i | input | 1 | USB byte read strobe |
| usb_rdata_o | output | 8 | Byte at the USB position of the USB-side buffer |
| usb_wr_i | input | 1 | USB byte write strobe (OUT mode) |
| usb_wdata_i | input | 8 | USB write byte |
| usb_done_i | input | 1 | IN: packet acknowledged. OUT: packet received |
| usb_rewind_i | input | 1 | Return the USB byte position to 0 |

## Verification
The IN variant is driven with short packets of different lengths armed back to back, so that a swap of buffers, a missed toggle or a stale count shows up as wrong bytes or a wrong length at the USB port. Writes issued while both buffers are armed test that the CPU side is blocked, and a rewind separates a retry from a release. The OUT variant receives two packets while the CPU holds neither, which fills both buffers and forces NAK. Writes made under NAK must not reach the next packet's count, and the acknowledge sequence shows whether data-available stays high when a second packet is waiting. An overlong packet, a discarded partial packet, a clamped count write and bus resets in mid-traffic cover the edge cases.

// File: rtl/ep_pkg.sv
package ep_pkg;
  typedef enum logic {
    EP_DIR_OUT = 1'b0,
    EP_DIR_IN  = 1'b1
  } ep_dir_e;

  localparam int unsigned EP_NBUF = 2;
endpackage

// File: rtl/ep_byte_ptr.sv
module ep_byte_ptr #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] ptr_o,
  output logic          end_o
);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic [CW-1:0] ptr_q;

  assign end_o = (ptr_q == LIMIT);
  assign ptr_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ptr_q <= '0;
    else if (clr_i)         ptr_q <= '0;
    else if (inc_i && !end_o) ptr_q <= ptr_q + 1'b1;
  end

  a_r12_ptr_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LIMIT);
  a_r12_ptr_hold_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o && !clr_i) |=> end_o);
endmodule

// File: rtl/ep_bank_mem.sv
module ep_bank_mem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  parameter int unsigned NBUF  = ep_pkg::EP_NBUF,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          wbank_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          abank_i,
  input  logic [AW-1:0] aaddr_i,
  output logic [DW-1:0] adata_o,
  input  logic          bbank_i,
  input  logic [AW-1:0] baddr_i,
  output logic [DW-1:0] bdata_o
);
  logic [DW-1:0] rd_a [NBUF];
  logic [DW-1:0] rd_b [NBUF];

  for (genvar b = 0; b < NBUF; b++) begin : g_bank
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && (wbank_i == 1'(b))) mem_q[waddr_i] <= wdata_i;
    end

    assign rd_a[b] = mem_q[aaddr_i];
    assign rd_b[b] = mem_q[baddr_i];
  end

  assign adata_o = rd_a[abank_i];
  assign bdata_o = rd_b[bbank_i];
endmodule

// File: rtl/ep_owner.sv
module ep_owner #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          fill_i,
  input  logic [CW-1:0] fill_cnt_i,
  input  logic          drain_i,
  output logic          fill_ok_o,
  output logic          drain_ok_o,
  output logic          prod_sel_o,
  output logic          cons_sel_o,
  output logic          prod_free_o,
  output logic          cons_ready_o,
  output logic [CW-1:0] prod_cnt_o,
  output logic [CW-1:0] cons_cnt_o
);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic [1:0]    full_q;
  logic [CW-1:0] cnt_q [2];
  logic          prod_q, cons_q;

  assign prod_free_o  = !full_q[prod_q];
  assign cons_ready_o = full_q[cons_q];
  assign fill_ok_o    = fill_i && prod_free_o;
  assign drain_ok_o   = drain_i && cons_ready_o;
  assign prod_sel_o   = prod_q;
  assign cons_sel_o   = cons_q;
  assign prod_cnt_o   = full_q[prod_q] ? cnt_q[prod_q] : '0;
  assign cons_cnt_o   = full_q[cons_q] ? cnt_q[cons_q] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
      prod_q <= 1'b0;
      cons_q <= 1'b0;
      for (int i = 0; i < 2; i++) cnt_q[i] <= '0;
    end else if (flush_i) begin
      full_q <= '0;
      prod_q <= 1'b0;
      cons_q <= 1'b0;
      for (int i = 0; i < 2; i++) cnt_q[i] <= '0;
    end else begin
      // producer and consumer on the same buffer cannot both succeed
      if (fill_ok_o) begin
        full_q[prod_q] <= 1'b1;
        cnt_q[prod_q]  <= fill_cnt_i;
        prod_q         <= ~prod_q;
      end
      if (drain_ok_o) begin
        full_q[cons_q] <= 1'b0;
        cons_q         <= ~cons_q;
      end
    end
  end

  a_r2_prod_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_ok_o && !flush_i) |=> (prod_q != $past(prod_q)));
  a_r5_cons_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_ok_o && !flush_i) |=> (cons_q != $past(cons_q)));
  a_r5_no_drain_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drain_i && !cons_ready_o && !fill_i && !flush_i) |=> $stable(full_q));
  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q[0] <= LIMIT) && (cnt_q[1] <= LIMIT));
  a_r13_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (full_q == 2'b00));
endmodule

// File: rtl/ep_pingpong_buf.sv
module ep_pingpong_buf #(
  parameter ep_pkg::ep_dir_e DIR = ep_pkg::EP_DIR_IN,
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned DW      = 8,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned CW     = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_reset_i,
  input  logic          cpu_wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          cpu_rd_i,
  output logic [DW-1:0] cpu_rdata_o,
  input  logic          cpu_cnt_wr_i,
  input  logic [CW-1:0] cpu_cnt_i,
  output logic [7:0]    cpu_cnt_o,
  input  logic          cpu_ack_i,
  output logic          irq_o,
  output logic          usb_nak_o,
  output logic [CW-1:0] usb_len_o,
  input  logic          usb_rd_i,
  output logic [DW-1:0] usb_rdata_o,
  input  logic          usb_wr_i,
  input  logic [DW-1:0] usb_wdata_i,
  input  logic          usb_done_i,
  input  logic          usb_rewind_i
);
  localparam bit            IS_IN = (DIR == ep_pkg::EP_DIR_IN);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic          fill, drain, fill_ok, drain_ok;
  logic [CW-1:0] fill_cnt, prod_cnt, cons_cnt, cpu_cnt_clamped;
  logic          prod_sel, cons_sel, prod_free, cons_ready;
  logic          cpu_sel, usb_sel, cpu_ok, usb_ok;
  logic [CW-1:0] cpu_ptr, usb_ptr;
  logic          cpu_end, usb_end;
  logic          cpu_clr, usb_clr, cpu_inc, usb_inc;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;
  logic [CW-1:0] cpu_side_cnt;

  assign cpu_cnt_clamped = (cpu_cnt_i > LIMIT) ? LIMIT : cpu_cnt_i;

  // direction decides who produces and who consumes
  assign fill     = IS_IN ? cpu_cnt_wr_i    : usb_done_i;
  assign fill_cnt = IS_IN ? cpu_cnt_clamped : usb_ptr;
  assign drain    = IS_IN ? usb_done_i      : cpu_ack_i;

  ep_owner #(.DEPTH(DEPTH), .CW(CW)) u_owner (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (bus_reset_i),
    .fill_i      (fill),
    .fill_cnt_i  (fill_cnt),
    .drain_i     (drain),
    .fill_ok_o   (fill_ok),
    .drain_ok_o  (drain_ok),
    .prod_sel_o  (prod_sel),
    .cons_sel_o  (cons_sel),
    .prod_free_o (prod_free),
    .cons_ready_o(cons_ready),
    .prod_cnt_o  (prod_cnt),
    .cons_cnt_o  (cons_cnt)
  );

  assign cpu_sel      = IS_IN ? prod_sel   : cons_sel;
  assign usb_sel      = IS_IN ? cons_sel   : prod_sel;
  assign cpu_ok       = IS_IN ? prod_free  : cons_ready;
  assign usb_ok       = IS_IN ? cons_ready : prod_free;
  assign cpu_side_cnt = IS_IN ? prod_cnt   : cons_cnt;

  assign cpu_clr = bus_reset_i || (IS_IN ? fill_ok : drain_ok);
  assign usb_clr = bus_reset_i || usb_rewind_i || (IS_IN ? drain_ok : fill_ok);
  assign cpu_inc = (cpu_wr_i || cpu_rd_i) && cpu_ok;
  assign usb_inc = (usb_wr_i || usb_rd_i) && usb_ok;

  ep_byte_ptr #(.DEPTH(DEPTH), .CW(CW)) u_cpu_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cpu_clr),
    .inc_i (cpu_inc),
    .ptr_o (cpu_ptr),
    .end_o (cpu_end)
  );

  ep_byte_ptr #(.DEPTH(DEPTH), .CW(CW)) u_usb_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (usb_clr),
    .inc_i (usb_inc),
    .ptr_o (usb_ptr),
    .end_o (usb_end)
  );

  assign mem_we    = IS_IN ? (cpu_wr_i && prod_free && !cpu_end && !cpu_clr)
                           : (usb_wr_i && prod_free && !usb_end && !usb_clr);
  assign mem_waddr = IS_IN ? cpu_ptr[AW-1:0] : usb_ptr[AW-1:0];
  assign mem_wdata = IS_IN ? cpu_wdata_i : usb_wdata_i;

  ep_bank_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .wbank_i(prod_sel),
    .waddr_i(mem_waddr),
    .wdata_i(mem_wdata),
    .abank_i(cpu_sel),
    .aaddr_i(cpu_ptr[AW-1:0]),
    .adata_o(cpu_rdata_o),
    .bbank_i(usb_sel),
    .baddr_i(usb_ptr[AW-1:0]),
    .bdata_o(usb_rdata_o)
  );

  assign cpu_cnt_o = {{(8-CW){1'b0}}, cpu_side_cnt};
  assign usb_len_o = IS_IN ? cons_cnt : '0;
  assign irq_o     = IS_IN ? prod_free : cons_ready;
  assign usb_nak_o = !usb_ok;

  a_r6_rewind_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usb_rewind_i |=> (usb_ptr == '0));
  a_r10_nak_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!IS_IN && usb_nak_o && usb_wr_i && !usb_done_i && !usb_rewind_i && !bus_reset_i
     && !cpu_ack_i) |=> ($stable(usb_ptr) && usb_nak_o));
  a_r8_armed_blocks_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (IS_IN && !irq_o && cpu_wr_i && !usb_done_i && !bus_reset_i) |=> $stable(cpu_ptr));
  a_r7_cnt_msb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_cnt_o[7] == 1'b0);
  a_r1_after_bus_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> (usb_nak_o == IS_IN) && (irq_o == IS_IN));
endmodule

// File: tb/ep_pingpong_buf_test.sv
module ep_pingpong_buf_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic bus_reset_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_bad = 0;

  // IN instance signals
  logic       i_cpu_wr = 0, i_cpu_rd = 0, i_cnt_wr = 0, i_ack = 0;
  logic [7:0] i_wdata = 0, i_rdata, i_cnt_o;
  logic [6:0] i_cnt = 0, i_len;
  logic       i_irq, i_nak;
  logic       i_usb_rd = 0, i_usb_wr = 0, i_done = 0, i_rew = 0;
  logic [7:0] i_usb_wdata = 0, i_usb_rdata;

  // OUT instance signals
  logic       o_cpu_wr = 0, o_cpu_rd = 0, o_cnt_wr = 0, o_ack = 0;
  logic [7:0] o_wdata = 0, o_rdata, o_cnt_o;
  logic [6:0] o_cnt = 0, o_len;
  logic       o_irq, o_nak;
  logic       o_usb_rd = 0, o_usb_wr = 0, o_done = 0, o_rew = 0;
  logic [7:0] o_usb_wdata = 0, o_usb_rdata;

  ep_pingpong_buf #(.DIR(ep_pkg::EP_DIR_IN)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_reset_i(bus_reset_i),
    .cpu_wr_i(i_cpu_wr), .cpu_wdata_i(i_wdata), .cpu_rd_i(i_cpu_rd),
    .cpu_rdata_o(i_rdata), .cpu_cnt_wr_i(i_cnt_wr), .cpu_cnt_i(i_cnt),
    .cpu_cnt_o(i_cnt_o), .cpu_ack_i(i_ack), .irq_o(i_irq), .usb_nak_o(i_nak),
    .usb_len_o(i_len), .usb_rd_i(i_usb_rd), .usb_rdata_o(i_usb_rdata),
    .usb_wr_i(i_usb_wr), .usb_wdata_i(i_usb_wdata), .usb_done_i(i_done),
    .usb_rewind_i(i_rew)
  );

  ep_pingpong_buf #(.DIR(ep_pkg::EP_DIR_OUT)) uut_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_reset_i(bus_reset_i),
    .cpu_wr_i(o_cpu_wr), .cpu_wdata_i(o_wdata), .cpu_rd_i(o_cpu_rd),
    .cpu_rdata_o(o_rdata), .cpu_cnt_wr_i(o_cnt_wr), .cpu_cnt_i(o_cnt),
    .cpu_cnt_o(o_cnt_o), .cpu_ack_i(o_ack), .irq_o(o_irq), .usb_nak_o(o_nak),
    .usb_len_o(o_len), .usb_rd_i(o_usb_rd), .usb_rdata_o(o_usb_rdata),
    .usb_wr_i(o_usb_wr), .usb_wdata_i(o_usb_wdata), .usb_done_i(o_done),
    .usb_rewind_i(o_rew)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // strobes are raised after a falling edge and dropped at the next one
  task automatic tick();
    @(negedge clk_i);
    #0.5;
  endtask

  task automatic in_wr(input logic [7:0] d);
    i_cpu_wr = 1; i_wdata = d; tick(); i_cpu_wr = 0;
  endtask
  task automatic in_arm(input logic [6:0] c);
    i_cnt_wr = 1; i_cnt = c; tick(); i_cnt_wr = 0;
  endtask
  task automatic in_usb_rd();  i_usb_rd = 1; tick(); i_usb_rd = 0; endtask
  task automatic in_done();    i_done = 1;   tick(); i_done = 0;   endtask
  task automatic in_rewind();  i_rew = 1;    tick(); i_rew = 0;    endtask
  task automatic out_wr(input logic [7:0] d);
    o_usb_wr = 1; o_usb_wdata = d; tick(); o_usb_wr = 0;
  endtask
  task automatic out_done();   o_done = 1;   tick(); o_done = 0;   endtask
  task automatic out_ack();    o_ack = 1;    tick(); o_ack = 0;    endtask
  task automatic out_cpu_rd(); o_cpu_rd = 1; tick(); o_cpu_rd = 0; endtask
  task automatic out_rewind(); o_rew = 1;    tick(); o_rew = 0;    endtask
  task automatic do_bus_reset(); bus_reset_i = 1; tick(); bus_reset_i = 0; endtask

  task automatic t_reset();
    chk("R1 in irq", i_irq, 1);
    chk("R1 in nak", i_nak, 1);
    chk("R1 in len", i_len, 0);
    chk("R1 in cnt", i_cnt_o, 0);
    chk("R1 out irq", o_irq, 0);
    chk("R1 out nak", o_nak, 0);
  endtask

  task automatic t_in_pingpong();
    for (int k = 0; k < 3; k++) in_wr(8'hA0 + 8'(k));
    in_arm(7'd3);
    chk("R3 irq one armed", i_irq, 1);
    chk("R4 nak off", i_nak, 0);
    chk("R4 len", i_len, 3);
    chk("R4 byte0", i_usb_rdata, 8'hA0);
    in_usb_rd();
    chk("R4 byte1", i_usb_rdata, 8'hA1);
    for (int k = 0; k < 5; k++) in_wr(8'hB0 + 8'(k));
    in_arm(7'd5);
    chk("R3 irq both armed", i_irq, 0);
    chk("R7 cpu cnt armed", i_cnt_o, 3);
    // R8: CPU side is armed, writes must not land
    in_wr(8'hEE);
    in_arm(7'd9);
    chk("R8 data kept", i_rdata, 8'hA0);
    chk("R8 cnt kept", i_cnt_o, 3);
    chk("R8 usb len kept", i_len, 3);
    in_rewind();
    chk("R6 rewind byte0", i_usb_rdata, 8'hA0);
    chk("R6 still armed", i_nak, 0);
    in_done();
    chk("R5 second len", i_len, 5);
    chk("R5 second byte0", i_usb_rdata, 8'hB0);
    chk("R3 irq after release", i_irq, 1);
    chk("R7 cpu cnt free", i_cnt_o, 0);
    for (int k = 0; k < 4; k++) in_usb_rd();
    chk("R4 last byte", i_usb_rdata, 8'hB4);
    in_done();
    chk("R4 nak empty", i_nak, 1);
    chk("R4 len empty", i_len, 0);
  endtask

  task automatic t_in_clamp();
    in_wr(8'h11);
    in_arm(7'd100);
    chk("R7 clamp", i_len, 64);
    chk("R7 msb zero", i_cnt_o[7], 0);
    in_done();
    chk("R5 back to nak", i_nak, 1);
  endtask

  task automatic t_in_bus_reset();
    in_wr(8'h21); in_arm(7'd1);
    in_wr(8'h22); in_arm(7'd1);
    chk("R13 pre irq", i_irq, 0);
    do_bus_reset();
    chk("R13 in nak", i_nak, 1);
    chk("R1 in irq after bus reset", i_irq, 1);
    in_wr(8'h33); in_arm(7'd1);
    chk("R13 fresh byte0", i_usb_rdata, 8'h33);
  endtask

  task automatic t_out_flow();
    out_wr(8'hC0); out_wr(8'hC1);
    chk("R9 no irq before done", o_irq, 0);
    out_done();
    chk("R9 irq", o_irq, 1);
    chk("R9 cnt", o_cnt_o, 2);
    chk("R9 byte0", o_rdata, 8'hC0);
    out_cpu_rd();
    chk("R9 byte1", o_rdata, 8'hC1);
    out_wr(8'hD0); out_done();
    chk("R10 nak both full", o_nak, 1);
    out_wr(8'h99); out_wr(8'h98);
    out_done();
    chk("R10 still nak", o_nak, 1);
    out_ack();
    chk("R11 irq stays", o_irq, 1);
    chk("R11 next cnt", o_cnt_o, 1);
    chk("R11 next byte", o_rdata, 8'hD0);
    chk("R10 nak released", o_nak, 0);
    out_ack();
    chk("R11 irq clears", o_irq, 0);
    chk("R7 out cnt empty", o_cnt_o, 0);
    out_wr(8'hE0); out_done();
    chk("R10 blocked bytes absent", o_cnt_o, 1);
    chk("R5 alternate buf", o_rdata, 8'hE0);
    out_ack();
  endtask

  task automatic t_out_edges();
    for (int k = 0; k < 70; k++) out_wr(8'(k));
    out_done();
    chk("R12 saturate", o_cnt_o, 64);
    chk("R12 first byte", o_rdata, 0);
    out_ack();
    out_wr(8'h51); out_wr(8'h52); out_wr(8'h53);
    out_rewind();
    out_wr(8'hF0);
    out_done();
    chk("R12 rewind cnt", o_cnt_o, 1);
    chk("R12 rewind data", o_rdata, 8'hF0);
    out_wr(8'h61); out_done();
    do_bus_reset();
    chk("R13 out irq", o_irq, 0);
    chk("R13 out nak", o_nak, 0);
    chk("R13 out cnt", o_cnt_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #0.5;
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_in_pingpong();
    t_in_clamp();
    t_in_bus_reset();
    t_out_flow();
    t_out_edges();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule